// File: doc/BRIEF.md
# Prescaled Match Timer Core

This block is a free-running timer for a peripheral subsystem. A prescale counter counts clock cycles up to a programmable limit. Each time it wraps, the main counter takes one step. Up to four compare channels watch the main counter. On a hit, a channel can latch a flag, zero the counter or halt it. Each channel also keeps a standby compare value, which is copied into the live compare register whenever the counter is zeroed. Software can therefore line up the next period without a race against the running count.

All state sits behind a plain synchronous register port. A write takes effect at the clock edge on which it is presented. A read returns the addressed value one cycle later. A single interrupt line is raised when any flagged channel has its interrupt enable set.

Top module: `match_timer_core`

## Requirements
- R1: After reset every register reads 0, `irq` is low, and neither counter moves.
- R2: Bit 0 of the control register (address 0) is the run enable. While it is 0, both the main counter (address 5) and the prescale counter (address 4) keep their values.
- R3: Bit 1 of the control register is a hold-in-reset. While it is 1, both counters are 0 on every following cycle, overriding direct writes and the run enable.
- R4: When running with prescale limit P (address 3), the prescale counter counts 0..P and wraps. The main counter advances once per wrap, so it steps every P+1 cycles (P=0 gives one step per cycle).
- R5: Channel k hits on a cycle where the prescale counter equals P while running and the main counter equals compare value k (address 8+k). On the next cycle, flag bit k of the flag register (address 1) is set, whatever the interrupt enable.
- R6: If match-control bit 3k+1 (address 2) is set, a hit on channel k makes the main counter 0 instead of incrementing it.
- R7: If match-control bit 3k+2 is set, a hit on channel k keeps the main counter at its value, wraps the prescale counter to 0, and clears control bit 0.
- R8: If match-control bit 24+k is set, compare value k is loaded from standby value k (address 16+k) on every cycle where the counter is zeroed by R3 or R6.
- R9: Writing the flag register clears each flag whose data bit is 1. Bits written as 0 are left alone, and a flag stays set until it is cleared.
- R10: `irq` is high exactly one cycle after some flag k is set while match-control bit 3k is set.
- R11: A write to the main counter or the prescale counter loads that value at the same edge and overrides counting and R6 zeroing.
- R12: When `rd_en` is high, `rdata` shows the addressed register on the next cycle and holds otherwise. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register word address |
| wdata | input | TW | Write data |
| rdata | output | TW | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
A corrupted prescale or main count shows up on the very next counter read, since the bench reads the count on every idle cycle. It also moves the cycle on which a hit fires, so `irq` and the flag register go out of step within one prescale period. A wrong compare or standby value stays hidden until the next counter reset or hit. At that point the reset comes at the wrong count, and the divergence appears in the read data within one period of the programmed match.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int ADR_W = 5;
  localparam int A_CTRL   = 0;
  localparam int A_FLAG   = 1;
  localparam int A_MCTL   = 2;
  localparam int A_PLIM   = 3;
  localparam int A_PCNT   = 4;
  localparam int A_CNT    = 5;
  localparam int A_MATCH  = 8;
  localparam int A_SHADOW = 16;
  localparam int RL_BASE  = 24;
  localparam int ACT_IE   = 0;
  localparam int ACT_RS   = 1;
  localparam int ACT_ST   = 2;

  function automatic int act_bit(input int ch, input int act);
    return 3 * ch + act;
  endfunction
endpackage

// File: rtl/mtc_prescaler.sv
module mtc_prescaler #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          clr,
  input  logic          ld,
  input  logic [TW-1:0] ld_val,
  input  logic [TW-1:0] limit,
  output logic [TW-1:0] pcnt,
  output logic          tick
);
  assign tick = run && (pcnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)    pcnt <= '0;
    else if (ld)       pcnt <= ld_val;
    else if (tick)     pcnt <= '0;
    else if (run)      pcnt <= pcnt + 1'b1;
  end

  // R4
  pcnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !ld && !clr && pcnt != limit) |=> pcnt == $past(pcnt) + 1'b1);
endmodule

// File: rtl/mtc_counter.sv
module mtc_counter #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          ld,
  input  logic [TW-1:0] ld_val,
  input  logic          tick,
  input  logic          zero_req,
  input  logic          hold_req,
  output logic [TW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (ld)         cnt <= ld_val;
    else if (tick) begin
      if (zero_req)      cnt <= '0;
      else if (!hold_req) cnt <= cnt + 1'b1;
    end
  end

  // R2
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld && !clr) |=> $stable(cnt));
  // R6
  cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && zero_req && !ld) |=> cnt == '0);
endmodule

// File: rtl/mtc_match_chan.sv
module mtc_match_chan #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] cnt,
  input  logic          tick,
  input  logic          mr_we,
  input  logic          sh_we,
  input  logic [TW-1:0] wdata,
  input  logic          reload_evt,
  input  logic          reload_en,
  input  logic          flag_clr,
  output logic          hit,
  output logic          flag,
  output logic [TW-1:0] mval,
  output logic [TW-1:0] sval
);
  assign hit = tick && (cnt == mval);

  always_ff @(posedge clk) begin
    if (rst)                          mval <= '0;
    else if (mr_we)                   mval <= wdata;
    else if (reload_evt && reload_en) mval <= sval;
  end

  always_ff @(posedge clk) begin
    if (rst)        sval <= '0;
    else if (sh_we) sval <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (flag && !flag_clr) || hit;
  end

  // R5
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);
  // R8
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (reload_evt && reload_en && !mr_we) |=> mval == $past(sval));
endmodule

// File: rtl/match_timer_core.sv
module match_timer_core
  import mtc_pkg::*;
#(
  parameter int TW  = 32,
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [ADR_W-1:0] addr,
  input  logic [TW-1:0]    wdata,
  output logic [TW-1:0]    rdata,
  output logic             irq
);
  logic [1:0]     ctrl_q;
  logic [TW-1:0]  mctl_q;
  logic [TW-1:0]  plim_q;
  logic [TW-1:0]  cnt_q;
  logic [TW-1:0]  pcnt_q;
  logic           run;
  logic           tick;
  logic           any_zero;
  logic           any_stop;
  logic           reload_evt;
  logic           ctrl_we, mctl_we, plim_we, pcnt_we, cnt_we, flag_we;
  logic [NCH-1:0] hit, flag, ie_v, rs_v, st_v, rl_v, mr_we, sh_we, fclr;
  logic [TW-1:0]  mval [NCH];
  logic [TW-1:0]  sval [NCH];
  logic [TW-1:0]  rd_mux;

  assign ctrl_we = wr_en && (addr == ADR_W'(A_CTRL));
  assign flag_we = wr_en && (addr == ADR_W'(A_FLAG));
  assign mctl_we = wr_en && (addr == ADR_W'(A_MCTL));
  assign plim_we = wr_en && (addr == ADR_W'(A_PLIM));
  assign pcnt_we = wr_en && (addr == ADR_W'(A_PCNT));
  assign cnt_we  = wr_en && (addr == ADR_W'(A_CNT));

  assign run        = ctrl_q[0] && !ctrl_q[1];
  assign any_zero   = |(hit & rs_v);
  assign any_stop   = |(hit & st_v);
  assign reload_evt = ctrl_q[1] || (any_zero && !cnt_we);

  always_ff @(posedge clk) begin
    if (rst)           ctrl_q <= '0;
    else if (ctrl_we)  ctrl_q <= wdata[1:0];
    else if (any_stop) ctrl_q[0] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mctl_q <= '0;
      plim_q <= '0;
    end else begin
      if (mctl_we) mctl_q <= wdata;
      if (plim_we) plim_q <= wdata;
    end
  end

  mtc_prescaler #(.TW(TW)) u_pre (
    .clk(clk), .rst(rst), .run(run), .clr(ctrl_q[1]), .ld(pcnt_we),
    .ld_val(wdata), .limit(plim_q), .pcnt(pcnt_q), .tick(tick)
  );

  mtc_counter #(.TW(TW)) u_cnt (
    .clk(clk), .rst(rst), .clr(ctrl_q[1]), .ld(cnt_we), .ld_val(wdata),
    .tick(tick), .zero_req(any_zero), .hold_req(any_stop), .cnt(cnt_q)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign ie_v[k]  = mctl_q[act_bit(k, ACT_IE)];
    assign rs_v[k]  = mctl_q[act_bit(k, ACT_RS)];
    assign st_v[k]  = mctl_q[act_bit(k, ACT_ST)];
    assign rl_v[k]  = mctl_q[RL_BASE + k];
    assign mr_we[k] = wr_en && (addr == ADR_W'(A_MATCH + k));
    assign sh_we[k] = wr_en && (addr == ADR_W'(A_SHADOW + k));
    assign fclr[k]  = flag_we && wdata[k];

    mtc_match_chan #(.TW(TW)) u_ch (
      .clk(clk), .rst(rst), .cnt(cnt_q), .tick(tick),
      .mr_we(mr_we[k]), .sh_we(sh_we[k]), .wdata(wdata),
      .reload_evt(reload_evt), .reload_en(rl_v[k]), .flag_clr(fclr[k]),
      .hit(hit[k]), .flag(flag[k]), .mval(mval[k]), .sval(sval[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADR_W'(A_CTRL))      rd_mux = TW'(ctrl_q);
    else if (addr == ADR_W'(A_FLAG)) rd_mux = TW'(flag);
    else if (addr == ADR_W'(A_MCTL)) rd_mux = mctl_q;
    else if (addr == ADR_W'(A_PLIM)) rd_mux = plim_q;
    else if (addr == ADR_W'(A_PCNT)) rd_mux = pcnt_q;
    else if (addr == ADR_W'(A_CNT))  rd_mux = cnt_q;
    for (int k = 0; k < NCH; k++) begin
      if (addr == ADR_W'(A_MATCH + k))  rd_mux = mval[k];
      if (addr == ADR_W'(A_SHADOW + k)) rd_mux = sval[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq <= |(flag & ie_v);
    end
  end

  // R7
  stop_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
    (any_stop && !ctrl_we) |=> !ctrl_q[0]);
  // R3
  hold_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[1] |=> (cnt_q == '0 && pcnt_q == '0));
  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(flag & ie_v)) |=> !irq);
  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/match_timer_core_bench.sv
`timescale 1ns/1ps
module match_timer_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  match_timer_core u_match_timer_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // behavioural reference state
  logic [1:0]  m_ctrl;
  logic [3:0]  m_flag;
  logic [31:0] m_mctl, m_plim, m_pc, m_tc;
  logic [31:0] m_mr [4];
  logic [31:0] m_sh [4];
  logic [31:0] e_rdata;
  logic        e_irq;

  function automatic logic [31:0] mreg(input logic [4:0] a);
    if (a == 0) return {30'b0, m_ctrl};
    if (a == 1) return {28'b0, m_flag};
    if (a == 2) return m_mctl;
    if (a == 3) return m_plim;
    if (a == 4) return m_pc;
    if (a == 5) return m_tc;
    if (a >= 8 && a < 12) return m_mr[a-8];
    if (a >= 16 && a < 20) return m_sh[a-16];
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = '0; m_flag = '0; m_mctl = '0; m_plim = '0; m_pc = '0; m_tc = '0;
      for (int k = 0; k < 4; k++) begin m_mr[k] = '0; m_sh[k] = '0; end
      e_rdata = '0; e_irq = 1'b0;
    end else begin
      logic tk, zr, sp, rev;
      logic [3:0] h, clrm;
      logic [31:0] n_pc, n_tc;
      logic [1:0] n_ctrl;
      if (rd_en) e_rdata = mreg(addr);
      e_irq = 1'b0;
      for (int k = 0; k < 4; k++) if (m_flag[k] && m_mctl[3*k]) e_irq = 1'b1;
      tk = m_ctrl[0] && !m_ctrl[1] && (m_pc == m_plim);
      zr = 1'b0; sp = 1'b0;
      for (int k = 0; k < 4; k++) begin
        h[k] = tk && (m_tc == m_mr[k]);
        if (h[k] && m_mctl[3*k+1]) zr = 1'b1;
        if (h[k] && m_mctl[3*k+2]) sp = 1'b1;
      end
      if (m_ctrl[1]) n_pc = 0;
      else if (wr_en && addr == 4) n_pc = wdata;
      else if (tk) n_pc = 0;
      else if (m_ctrl[0]) n_pc = m_pc + 1;
      else n_pc = m_pc;
      if (m_ctrl[1]) n_tc = 0;
      else if (wr_en && addr == 5) n_tc = wdata;
      else if (tk) n_tc = zr ? 0 : (sp ? m_tc : m_tc + 1);
      else n_tc = m_tc;
      rev = m_ctrl[1] || (zr && !(wr_en && addr == 5));
      if (wr_en && addr == 0) n_ctrl = wdata[1:0];
      else if (sp) n_ctrl = {m_ctrl[1], 1'b0};
      else n_ctrl = m_ctrl;
      clrm = (wr_en && addr == 1) ? wdata[3:0] : 4'b0;
      for (int k = 0; k < 4; k++) begin
        if (wr_en && addr == 5'(8 + k)) m_mr[k] = wdata;
        else if (rev && m_mctl[24+k]) m_mr[k] = m_sh[k];
      end
      for (int k = 0; k < 4; k++) if (wr_en && addr == 5'(16 + k)) m_sh[k] = wdata;
      if (wr_en && addr == 2) m_mctl = wdata;
      if (wr_en && addr == 3) m_plim = wdata;
      m_flag = (m_flag & ~clrm) | h;
      m_pc = n_pc; m_tc = n_tc; m_ctrl = n_ctrl;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (rdata !== e_rdata) begin
        errors++;
        $display("FAIL %s rdata actual %0d expected %0d at %0t", cur_req, rdata, e_rdata, $time);
      end
      checks++;
      if (irq !== e_irq) begin
        errors++;
        $display("FAIL %s irq actual %0b expected %0b at %0t", cur_req, irq, e_irq, $time);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_en = 1'b0; rd_en = 1'b1; addr = 5'd5;
    end
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
  endtask
  task automatic rd(input logic [4:0] a);
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b1; addr = a;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    for (int a = 0; a < 20; a++) rd(5'(a));
    idle(4);
    cur_req = "R4";
    wr(3, 2); wr(0, 1); idle(25);
    cur_req = "R2";
    wr(0, 0); idle(6); rd(4); wr(0, 1);
    cur_req = "R11";
    wr(5, 100); wr(4, 1); idle(5); rd(4);
    cur_req = "R6";
    wr(8, 110); wr(2, 32'h3); idle(45);
    cur_req = "R10";
    rd(1); idle(3);
    cur_req = "R9";
    wr(1, 0); rd(1); wr(1, 1); rd(1); idle(3);
    cur_req = "R7";
    wr(5, 0); wr(9, 8); wr(2, 32'h28); idle(40); rd(0); rd(1); idle(5);
    cur_req = "R5";
    wr(2, 0); wr(1, 4'hf); wr(0, 1); wr(10, 3); idle(20); rd(1);
    cur_req = "R8";
    wr(1, 4'hf); wr(16, 20); wr(8, 5); wr(5, 0);
    wr(2, 32'h0100_0003); idle(30); rd(8); idle(80); rd(8); rd(16);
    cur_req = "R3";
    wr(0, 3); idle(4); wr(5, 77); idle(2); wr(4, 1); idle(2); rd(8); wr(0, 1); idle(10);
    cur_req = "R4";
    wr(3, 0); wr(2, 0); wr(5, 0); idle(12);
    cur_req = "R12";
    rd(7); rd(31); rd(12); wr(0, 0); rd(2); idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired after %0d cycles, expected completion", 100000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule